// File: doc/BRIEF.md
# Watchdog Counter with Keyed Run Control

This block is a register-mapped watchdog counter advanced by a slow tick, nominally 32768 Hz, that arrives as a one-cycle enable on the system clock. Software reaches it through a plain register port with address, write enable, write data, read enable and read data. A 16-bit run-control register takes two-word key sequences that start or halt the counter. A configuration register holds the tick divider settings. A load register supplies the starting value, and a count register returns the live count.

When counting starts, the count is loaded from the load register. The count then advances on divided ticks. When it passes the all-ones value, it reloads and gives a one-cycle reset request. The divider settings cannot be changed while the counter runs. Software can find out whether the counter is running by reading the count twice, at least one divided period apart, and comparing the two values.

Top module: `wdt_keyed_top`

## Requirements
- R1: Writing 16'hBBBB and then 16'h4444 as consecutive writes to the run-control register starts the counter, and the count takes the load register value on the edge of the second write.
- R2: Writing 16'hAAAA and then 16'h5555 as consecutive writes to the run-control register halts the counter, and the count then holds its value through any number of ticks.
- R3: A read of the run-control register returns the last 16-bit value written, zero-extended. A lone 16'h4444 that does not follow 16'hBBBB is stored but does not start the counter.
- R4: Writing any other value to the run-control register between the two key words cancels the pending sequence, and the first word must be written again. Writes to other registers do not disturb a pending sequence.
- R5: In the configuration register, bit 5 enables the divider and bits 4:2 hold an exponent e. When the divider is enabled, the count advances once every 2^e ticks, and the division phase restarts at each start. When it is disabled, the count advances on every tick.
- R6: After reset, the configuration register reads 32'h20, the run-control register reads 32'h5555, the count and load registers read 0, the counter is halted and the reset request is low.
- R7: Configuration writes made while the counter runs are ignored. Configuration writes made while it is halted take effect.
- R8: When the count advances past 32'hFFFFFFFF, the reset request is high for exactly one cycle and the count reloads from the load register.
- R9: A complete key sequence for the state the counter already has does nothing: a running count is not reloaded, and a halted count stays halted.
- R10: The register addresses are 0 for configuration, 1 for load, 2 for count and 3 for run control. Read data is valid in the same cycle as the read enable and is zero when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse for each slow tick |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data |
| rst_req_o | output | 1 | One-cycle reset request on count wrap |

## Verification
The hardest situation to reach is a count wrap at a known division phase. The test writes a load value two below the wrap point while the counter is halted, starts it, and gives single tick pulses, so that the reset request can be checked on its exact cycle and its drop checked on the next cycle. The locked configuration is reached by starting with the default divider, trying a new setting that must be ignored, then halting and rewriting it. Four-tick and every-tick advance are then measured from a fresh start.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned KEY_W = 16;

  localparam logic [KEY_W-1:0] KEY_RUN_A  = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_RUN_B  = 16'h4444;
  localparam logic [KEY_W-1:0] KEY_HALT_A = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_HALT_B = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_RESET  = 16'h5555;

  localparam int unsigned CFG_EN_BIT  = 5;
  localparam int unsigned CFG_EXP_LSB = 2;

  localparam logic [3:0] A_CFG  = 4'd0;
  localparam logic [3:0] A_LOAD = 4'd1;
  localparam logic [3:0] A_CNT  = 4'd2;
  localparam logic [3:0] A_KEY  = 4'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HALT = 2'd2
  } seq_e;
endpackage

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_wdata_i,
  output logic             run_o,
  output logic             start_o,
  output logic [KEY_W-1:0] key_o
);
  seq_e             seq_q, seq_d;
  logic             run_q;
  logic [KEY_W-1:0] key_q;
  logic             hit_run, hit_halt;

  assign hit_run  = key_we_i && key_wdata_i == KEY_RUN_B  && seq_q == SEQ_RUN;
  assign hit_halt = key_we_i && key_wdata_i == KEY_HALT_B && seq_q == SEQ_HALT;
  assign start_o  = hit_run && !run_q;

  always_comb begin
    seq_d = seq_q;
    if (key_we_i) begin
      if (key_wdata_i == KEY_RUN_A)       seq_d = SEQ_RUN;
      else if (key_wdata_i == KEY_HALT_A) seq_d = SEQ_HALT;
      else                                seq_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= SEQ_IDLE;
      run_q <= 1'b0;
      key_q <= KEY_RESET;
    end else begin
      seq_q <= seq_d;
      if (key_we_i) key_q <= key_wdata_i;
      if (hit_run)       run_q <= 1'b1;
      else if (hit_halt) run_q <= 1'b0;
    end
  end

  assign run_o = run_q;
  assign key_o = key_q;

  AST_START_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(key_we_i && key_wdata_i == KEY_RUN_B && seq_q == SEQ_RUN)); // R1
  AST_HALT_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(key_we_i && key_wdata_i == KEY_HALT_B && seq_q == SEQ_HALT)); // R2
  AST_KEY_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_we_i |=> key_q == $past(key_wdata_i)); // R3
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             pre_en_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             step_o
);
  localparam int unsigned DIV_W = (2 ** EXP_W) - 1;

  logic [DIV_W-1:0] div_q, mask;

  // exponent at max wraps the shifted one to zero, giving an all-ones mask
  assign mask   = (DIV_W'(1) << exp_i) - DIV_W'(1);
  assign step_o = run_i && tick_i && (!pre_en_i || (div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             div_q <= '0;
    else if (clr_i)          div_q <= '0;
    else if (run_i && tick_i) div_q <= div_q + DIV_W'(1);
  end

  AST_STEP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> tick_i && run_i); // R5
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;
  logic             at_top;

  assign at_top = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (run_i && step_i) begin
        if (at_top) begin
          cnt_q  <= load_val_i;
          wrap_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  AST_HOLD_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !load_i |=> $stable(cnt_q)); // R2
  AST_WRAP_FROM_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> $past(at_top && step_i && run_i)); // R8
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EXP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  localparam int unsigned CNT_W = DATA_W;

  logic             pre_en_q;
  logic [EXP_W-1:0] exp_q;
  logic [CNT_W-1:0] load_q, cnt;
  logic [KEY_W-1:0] key;
  logic             run, start, step;
  logic             wr_cfg, wr_load, wr_key;
  logic             unused_wdata;

  assign wr_cfg  = we_i && addr_i == ADDR_W'(A_CFG);
  assign wr_load = we_i && addr_i == ADDR_W'(A_LOAD);
  assign wr_key  = we_i && addr_i == ADDR_W'(A_KEY);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_en_q <= 1'b1;
      exp_q    <= '0;
      load_q   <= '0;
    end else begin
      if (wr_cfg && !run) begin
        pre_en_q <= wdata_i[CFG_EN_BIT];
        exp_q    <= wdata_i[CFG_EXP_LSB +: EXP_W];
      end
      if (wr_load) load_q <= wdata_i[CNT_W-1:0];
    end
  end

  wdt_key_fsm u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_we_i    (wr_key),
    .key_wdata_i (wdata_i[KEY_W-1:0]),
    .run_o       (run),
    .start_o     (start),
    .key_o       (key)
  );

  wdt_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run),
    .clr_i    (start),
    .pre_en_i (pre_en_q),
    .exp_i    (exp_q),
    .step_o   (step)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .load_i     (start),
    .load_val_i (load_q),
    .step_i     (step),
    .cnt_o      (cnt),
    .wrap_o     (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (addr_i)
        ADDR_W'(A_CFG): begin
          rdata_o[CFG_EN_BIT]              = pre_en_q;
          rdata_o[CFG_EXP_LSB +: EXP_W]    = exp_q;
        end
        ADDR_W'(A_LOAD): rdata_o = load_q;
        ADDR_W'(A_CNT):  rdata_o = cnt;
        ADDR_W'(A_KEY):  rdata_o = DATA_W'(key);
        default:         rdata_o = '0;
      endcase
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && wr_cfg |=> $stable(pre_en_q) && $stable(exp_q)); // R7
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o && load_q != '1 |=> !rst_req_o); // R8
  AST_NO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0); // R10
endmodule

// File: tb/wdt_keyed_top_test.sv
module wdt_keyed_top_test;
  localparam time CLK_P = 10ns;

  typedef struct {
    logic [3:0]  a;
    logic [31:0] v;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        req;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t sb[$];

  always #(CLK_P / 2) clk = ~clk;

  wdt_keyed_top uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .addr_i    (addr),
    .we_i      (we),
    .wdata_i   (wdata),
    .re_i      (re),
    .rdata_o   (rdata),
    .rst_req_o (req)
  );

  // monitor: compares each read against the oldest expected item
  always @(negedge clk) begin
    if (re) begin
      if (sb.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard empty: actual %h expected none", rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (rdata !== e.v) begin
          n_fail++;
          $display("FAIL %s addr %0d: actual %h expected %h", e.tag, e.a, rdata, e.v);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    e.a = a; e.v = v; e.tag = tag;
    sb.push_back(e);
    addr = a; re = 1'b1;
    @(posedge clk); #1;
    re = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  task automatic chk_req(input logic v, input string tag);
    @(negedge clk);
    n_run++;
    if (req !== v) begin
      n_fail++;
      $display("FAIL %s rst_req: actual %b expected %b", tag, req, v);
    end
  endtask

  task automatic start_seq();
    wr(4'd3, 32'hBBBB); wr(4'd3, 32'h4444);
  endtask

  task automatic halt_seq();
    wr(4'd3, 32'hAAAA); wr(4'd3, 32'h5555);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R6 reset state, R10 map
    rd(4'd0, 32'h20, "R6 cfg");
    rd(4'd3, 32'h5555, "R6 key");
    rd(4'd2, 32'h0, "R6 count");
    rd(4'd1, 32'h0, "R6 load");
    chk_req(1'b0, "R6");
    @(posedge clk); #1;
    wr(4'd1, 32'd100);
    rd(4'd1, 32'd100, "R10 load");

    // R3 lone second key word
    wr(4'd3, 32'h4444);
    rd(4'd3, 32'h4444, "R3 readback");
    ticks(3);
    rd(4'd2, 32'h0, "R3 no start");

    // R4 cancel
    wr(4'd3, 32'hBBBB); wr(4'd3, 32'h1234); wr(4'd3, 32'h4444);
    ticks(2);
    rd(4'd2, 32'h0, "R4 cancelled");

    // R4 other register writes keep sequence; R1 load on start
    wr(4'd3, 32'hBBBB); wr(4'd1, 32'd100); wr(4'd3, 32'h4444);
    rd(4'd2, 32'd100, "R1 loaded");
    ticks(3);
    rd(4'd2, 32'd103, "R5 every tick exp0");

    // R7 locked while running
    wr(4'd0, 32'h2C);
    rd(4'd0, 32'h20, "R7 locked");

    // R9 redundant start
    start_seq();
    rd(4'd2, 32'd103, "R9 no reload");
    ticks(1);
    rd(4'd2, 32'd104, "R9 still running");

    // R2 halt
    halt_seq();
    ticks(2);
    rd(4'd2, 32'd104, "R2 halted");
    halt_seq();
    ticks(1);
    rd(4'd2, 32'd104, "R9 halt when halted");

    // R7 unlocked, R5 divide by 4
    wr(4'd0, 32'h28);
    rd(4'd0, 32'h28, "R7 accepted");
    start_seq();
    ticks(3);
    rd(4'd2, 32'd100, "R5 exp2 three ticks");
    ticks(1);
    rd(4'd2, 32'd101, "R5 exp2 fourth tick");
    ticks(4);
    rd(4'd2, 32'd102, "R5 exp2 eighth tick");

    // R5 divider disabled
    halt_seq();
    wr(4'd0, 32'h08);
    rd(4'd0, 32'h08, "R7 cfg disabled");
    start_seq();
    ticks(2);
    rd(4'd2, 32'd102, "R5 disabled every tick");

    // R8 wrap
    halt_seq();
    wr(4'd1, 32'hFFFF_FFFE);
    wr(4'd0, 32'h20);
    start_seq();
    rd(4'd2, 32'hFFFF_FFFE, "R8 preload");
    tick = 1'b1; @(posedge clk); #1; tick = 1'b0;
    chk_req(1'b0, "R8 before wrap");
    @(posedge clk); #1;
    rd(4'd2, 32'hFFFF_FFFF, "R8 at top");
    tick = 1'b1; @(posedge clk); #1; tick = 1'b0;
    chk_req(1'b1, "R8 pulse");
    @(posedge clk); #1;
    chk_req(1'b0, "R8 pulse ends");
    @(posedge clk); #1;
    rd(4'd2, 32'hFFFF_FFFE, "R8 reloaded");

    // R10 zero when idle
    @(negedge clk);
    n_run++;
    if (rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL R10 idle rdata: actual %h expected %h", rdata, 32'h0);
    end

    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule